// File: doc/BRIEF.md
# Branch Target Landing Checker

This block sits beside the retire stage of an in-order core and enforces landing-pad discipline on indirect branches. It keeps a 2-bit branch-type state that records what kind of register branch, if any, the previous instruction was. When an instruction retires on a guarded page while that state is nonzero, the block checks whether the instruction is a landing pad that accepts this branch type. If it is not, the block raises a one-cycle fault pulse.

One instruction is presented per cycle in which `valid` is high. The block sees only a coarse instruction class, the 7-bit hint immediate, the base register number of a register branch, and a flag that says whether the current page is guarded. The check uses the state left by the previous instruction. The state is then rewritten from the current instruction. A faulting instruction leaves the state at 0.

Top module: `btgt_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stored branch type becomes 0. After reset, `btype` reads 0 and `fault` is low.
- R2: A register branch (`iclass`=1) that does not fault sets the branch type to 1 when `guarded` is low or `rn` is 16 or 17. On a guarded page through any other register, it sets the branch type to 3.
- R3: A register branch-and-link (`iclass`=2) that does not fault sets the branch type to 2.
- R4: Every other valid instruction sets the branch type to 0. This covers `iclass` 0, 3, 4, 5, 6 and 7, hints of any immediate, and return.
- R5: When `guarded` is low or the stored branch type is 0, no instruction faults, whatever its class or hint immediate.
- R6: On a guarded page with a nonzero branch type, an exception instruction (`iclass`=5) never faults. An ordinary instruction (`iclass` 0, 1, 2, 6, 7) faults, and so does a hint whose immediate is not 32, 34, 36 or 38.
- R7: A hint with immediate 32 (bare landing pad) faults for every nonzero branch type on a guarded page.
- R8: A hint with immediate 34 (call pad) faults only on type 3. Immediate 36 (jump pad) faults only on type 2. Immediate 38 (jump-or-call pad) accepts types 1, 2 and 3.
- R9: The pointer-authentication landing instruction (`iclass`=4) faults on type 3 and is accepted on types 1 and 2.
- R10: `fault` is combinational and aligned with the checked instruction. After a faulting instruction, the branch type is 0 whatever that instruction's class.
- R11: While `valid` is low, `fault` stays low and the branch type holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid | input | 1 | An instruction retires this cycle |
| iclass | input | 3 | 0 other, 1 register branch, 2 register branch-and-link, 3 hint, 4 pointer-auth landing, 5 breakpoint/halt exception |
| hint_imm | input | 7 | Hint immediate, used when `iclass`=3 |
| rn | input | 5 | Base register number of a register branch |
| guarded | input | 1 | The current PC lies in a guarded page |
| fault | output | 1 | The current instruction may not execute |
| btype | output | 2 | Stored branch type |

## Verification
Each landing variant is tried against each nonzero branch type on a guarded page. This covers the bare, call, jump and jump-or-call hints and the pointer-auth landing. The resulting accept and reject pattern separates every variant from its neighbours. Register branches are issued through x16, x17 and an ordinary register, on guarded and unguarded pages. This shows the type-1 and type-3 encodings depend on both conditions. Further tests run a landing on an unguarded page, an instruction after a type-0 state, and a non-landing hint, exception or plain instruction after a branch. An idle cycle and a fault followed by a clean instruction show the no-op, fault-clearing and hold paths.

// File: rtl/btgt_checker.sv
module btgt_checker #(
  parameter int BT_W   = 2,
  parameter int CLS_W  = 3,
  parameter int IMM_W  = 7,
  parameter int REG_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [CLS_W-1:0] iclass,
  input  logic [IMM_W-1:0] hint_imm,
  input  logic [REG_W-1:0] rn,
  input  logic             guarded,
  output logic             fault,
  output logic [BT_W-1:0]  btype
);

  localparam logic [CLS_W-1:0] C_BR   = CLS_W'(1);
  localparam logic [CLS_W-1:0] C_BLR  = CLS_W'(2);
  localparam logic [CLS_W-1:0] C_HINT = CLS_W'(3);
  localparam logic [CLS_W-1:0] C_PAL  = CLS_W'(4);
  localparam logic [CLS_W-1:0] C_EXC  = CLS_W'(5);

  localparam logic [IMM_W-1:0] PAD_ANY  = IMM_W'(32);
  localparam logic [IMM_W-1:0] PAD_CALL = IMM_W'(34);
  localparam logic [IMM_W-1:0] PAD_JMP  = IMM_W'(36);
  localparam logic [IMM_W-1:0] PAD_JC   = IMM_W'(38);

  localparam logic [BT_W-1:0] BT_NONE  = BT_W'(0);
  localparam logic [BT_W-1:0] BT_SOFT  = BT_W'(1);
  localparam logic [BT_W-1:0] BT_CALL  = BT_W'(2);
  localparam logic [BT_W-1:0] BT_HARD  = BT_W'(3);

  logic [BT_W-1:0] bt_q, bt_new;
  logic            landing_ok, checking, ip_reg;

  assign btype    = bt_q;
  assign checking = valid && guarded && (bt_q != BT_NONE);
  assign ip_reg   = (rn == REG_W'(16)) || (rn == REG_W'(17));

  always_comb begin
    landing_ok = 1'b0;
    unique case (iclass)
      C_EXC:  landing_ok = 1'b1;
      C_PAL:  landing_ok = (bt_q != BT_HARD);
      C_HINT: begin
        if (hint_imm == PAD_CALL)     landing_ok = (bt_q != BT_HARD);
        else if (hint_imm == PAD_JMP) landing_ok = (bt_q != BT_CALL);
        else if (hint_imm == PAD_JC)  landing_ok = 1'b1;
        else                          landing_ok = 1'b0;
      end
      default: landing_ok = 1'b0;
    endcase
  end

  assign fault = checking && !landing_ok;

  always_comb begin
    if (fault)                 bt_new = BT_NONE;
    else if (iclass == C_BR)   bt_new = (!guarded || ip_reg) ? BT_SOFT : BT_HARD;
    else if (iclass == C_BLR)  bt_new = BT_CALL;
    else                       bt_new = BT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bt_q <= BT_NONE;
    else if (valid) bt_q <= bt_new;
  end

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(btype));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !fault);
  a_r5_unchecked_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!guarded || btype == BT_NONE) |-> !fault);
  a_r10_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> btype == BT_NONE);
  a_r3_blr_type: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !fault && iclass == C_BLR) |=> btype == BT_CALL);
  a_r6_exc_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && iclass == C_EXC) |-> !fault);
  a_r8_jc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && iclass == C_HINT && hint_imm == PAD_JC) |-> !fault);
  a_r7_bare_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && guarded && btype != BT_NONE && iclass == C_HINT && hint_imm == PAD_ANY) |-> fault);

endmodule

// File: tb/test_btgt_checker.sv
module test_btgt_checker;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [2:0] iclass = '0;
  logic [6:0] hint_imm = '0;
  logic [4:0] rn = '0;
  logic       guarded = 1'b0;
  logic       fault;
  logic [1:0] btype;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  btgt_checker i_btgt_checker (
    .clk(clk), .rst_n(rst_n), .valid(valid), .iclass(iclass),
    .hint_imm(hint_imm), .rn(rn), .guarded(guarded),
    .fault(fault), .btype(btype)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, check fault mid-cycle, check btype after edge
  task automatic step(input bit v, input int cls, input int imm, input int r,
                      input bit g, input int exp_fault, input int exp_bt,
                      input string req);
    @(negedge clk);
    valid = v; iclass = 3'(cls); hint_imm = 7'(imm); rn = 5'(r); guarded = g;
    #1;
    chk({req, " fault"}, int'(fault), exp_fault);
    @(posedge clk); #1;
    chk({req, " btype"}, int'(btype), exp_bt);
  endtask

  task automatic prime(input int t);
    if (t == 1)      step(1, 1, 0, 3, 0, 0, 1, "R2 prime1");
    else if (t == 2) step(1, 2, 0, 4, 0, 0, 2, "R3 prime2");
    else             step(1, 1, 0, 5, 1, 0, 3, "R2 prime3");
  endtask

  function automatic int pad_faults(input int cls, input int imm, input int t);
    if (cls == 5) return 0;
    if (cls == 4) return (t == 3) ? 1 : 0;
    if (cls != 3) return 1;
    case (imm)
      34: return (t == 3) ? 1 : 0;
      36: return (t == 2) ? 1 : 0;
      38: return 0;
      default: return 1;
    endcase
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 btype", int'(btype), 0);
    chk("R1 fault", int'(fault), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_br_types();
    step(1, 1, 0, 16, 1, 0, 1, "R2 br x16 guarded");
    step(1, 3, 38, 0, 1, 0, 0, "R4 pad clears");
    step(1, 1, 0, 17, 1, 0, 1, "R2 br x17 guarded");
    step(1, 0, 0, 0, 0, 0, 0, "R4 other clears");
    step(1, 1, 0, 9, 0, 0, 1, "R2 br unguarded");
    step(1, 0, 0, 0, 0, 0, 0, "R4 other clears");
    step(1, 1, 0, 9, 1, 0, 3, "R2 br guarded x9");
    step(1, 3, 38, 0, 1, 0, 0, "R8 jc accepts 3");
    step(1, 2, 0, 1, 1, 0, 2, "R3 blr");
    step(1, 6, 0, 0, 0, 0, 0, "R4 class6 clears");
  endtask

  task automatic t_matrix();
    int pads [5] = '{32, 34, 36, 38, -1};
    for (int p = 0; p < 5; p++) begin
      for (int t = 1; t <= 3; t++) begin
        int cls = (pads[p] < 0) ? 4 : 3;
        int f = pad_faults(cls, pads[p], t);
        prime(t);
        if (cls == 4)        step(1, cls, 0, 0, 1, f, 0, "R9 pauth landing");
        else if (pads[p] == 32) step(1, cls, pads[p], 0, 1, f, 0, "R7 bare pad");
        else                 step(1, cls, pads[p], 0, 1, f, 0, "R8 pad variant");
      end
    end
  endtask

  task automatic t_unchecked();
    prime(3);
    step(1, 0, 0, 0, 0, 0, 0, "R5 unguarded plain");
    step(1, 3, 32, 0, 1, 0, 0, "R5 type0 bare pad");
    step(1, 0, 0, 0, 1, 0, 0, "R5 type0 plain guarded");
    prime(2);
    step(1, 3, 36, 0, 0, 0, 0, "R5 unguarded jump pad");
  endtask

  task automatic t_guarded_others();
    prime(1);
    step(1, 5, 0, 0, 1, 0, 0, "R6 exception allowed");
    prime(3);
    step(1, 3, 0, 0, 1, 1, 0, "R6 nop hint faults");
    prime(2);
    step(1, 0, 0, 0, 1, 1, 0, "R6 plain faults");
    prime(3);
    step(1, 2, 0, 0, 1, 1, 0, "R10 faulting blr clears");
    step(1, 0, 0, 0, 1, 0, 0, "R10 next clean");
    prime(1);
    step(1, 1, 0, 3, 1, 1, 0, "R10 faulting br clears");
  endtask

  task automatic t_idle();
    prime(3);
    step(0, 0, 0, 0, 1, 0, 3, "R11 idle hold");
    step(0, 1, 0, 16, 0, 0, 3, "R11 idle branch ignored");
    step(1, 3, 36, 0, 1, 0, 0, "R11 pad after idle");
  endtask

  initial begin
    t_reset();
    t_br_types();
    t_matrix();
    t_unchecked();
    t_guarded_others();
    t_idle();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule